// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a TLB fill entry by walking a three-level radix page table in memory. A requester hands it a virtual address, an access type (read, write or execute), a privilege level and the page number of the table root. The walker then fetches one page table entry per level over a simple memory request/response port. It validates each entry, stops at the first leaf, and checks the leaf's permission bits and superpage alignment. When the accessed or dirty bit has to change, it writes the updated entry back. It ends the walk with either a fill entry for the TLB or a fault.

An external protection checker answers, in the same cycle, whether a given physical address may be touched. The walker consults it before every entry fetch, always at supervisor privilege with a read access type. Before a write-back it consults it again, this time with the requester's own privilege and access type. Any fault, whether a page fault or an access fault, reports the virtual address that started the walk. A clean page that is filled on a non-write access is handed to the TLB without write permission, so a later store walks the table again and marks the page dirty.

Only one walk is in flight at a time. The block accepts a request only while `req_ready` is high.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle; a request is taken when `req_valid` and `req_ready` are both high, and requests presented while busy are ignored.
- R2: The first entry address is the root page number shifted left by 12 plus index(2) times 8. Each later address is the pointer entry's page number (entry bits 53:10) shifted left by 12 plus index(L) times 8, where index(L) is virtual address bits [12+9L +: 9].
- R3: Every entry read is issued in the same cycle as an approved protection check of its address at privilege 2'b01 (supervisor) with access code 2'b00 (read). A refused check issues no read and ends the walk with an access fault.
- R4: An entry whose valid bit (bit 0) is clear, or whose read bit (bit 1) is clear while its write bit (bit 2) is set, ends the walk with a page fault.
- R5: An entry with its read bit or execute bit (bit 3) set is a leaf. Any other entry is a pointer, and the walk descends one level. A pointer found at level 0 ends the walk with a page fault.
- R6: Access codes are 2'b00 read, 2'b01 write and 2'b10 execute. A leaf lacking the read, write or execute bit that the access needs gives a page fault.
- R7: A leaf at level 1 or 2 whose lowest page-number field (bits 18:10) is nonzero gives a page fault. So does a leaf at level 2 whose middle field (bits 27:19) is nonzero.
- R8: A passing leaf gets its accessed bit (bit 6) set. On a write access it also gets its dirty bit (bit 7) set. If either bit changed, the updated entry is written to the address it was read from.
- R9: Before a write-back, the entry address is protection-checked with the requester's privilege and access code. If the check is refused, the walk ends with an access fault and nothing is written or filled.
- R10: A fill carries page size bits 12+9L for leaf level L, the virtual address with the bits below that size cleared, the leaf page number, and the updated entry.
- R11: The filled entry has its write bit cleared when its dirty bit is clear and the access is not a write.
- R12: Each walk ends in exactly one one-cycle pulse, either on `fill_valid` or on `fault_valid`. A fault drives `fault_vaddr` with the requested virtual address and `fault_access` with 1 for a protection fault or 0 for a page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 39 | Virtual address to translate |
| req_acc | input | 2 | Access code: 00 read, 01 write, 10 execute |
| req_priv | input | 2 | Requester privilege: 00 user, 01 supervisor, 11 machine |
| req_root | input | 44 | Page number of the root table |
| chk_valid | output | 1 | Protection query present |
| chk_addr | output | 56 | Physical address under query |
| chk_priv | output | 2 | Privilege used for the query |
| chk_acc | output | 2 | Access code used for the query |
| chk_allow | input | 1 | Same-cycle protection verdict, 1 = allowed |
| mem_req_valid | output | 1 | Memory access issued this cycle |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 56 | Entry physical address |
| mem_req_wdata | output | 64 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 64 | Returned entry |
| fill_valid | output | 1 | One-cycle TLB fill pulse |
| fill_vaddr | output | 39 | Virtual address aligned to the page size |
| fill_ppn | output | 44 | Leaf physical page number |
| fill_page_bits | output | 6 | log2 of the page size |
| fill_pte | output | 64 | Entry given to the TLB |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_access | output | 1 | 1 = protection (access) fault, 0 = page fault |
| fault_vaddr | output | 39 | Virtual address of the faulting request |

## Verification
Some properties are checked by assertions on every cycle. Each entry read must coincide with an approved supervisor read query at the same address. Each write-back must be checked at the captured requester privilege and access code. Fill and fault never pulse together, a fault carries the captured address, and a fill is page-aligned and marked accessed, dirty on writes and write-protected when clean. Other behaviour shows only in the bench's scenarios, where a behavioural model walks the same sparse memory: the exact order of entry addresses, the decision that ends each walk (invalid, pointer at level 0, permission, misaligned superpage, refused queries), the written-back value, and that a request presented mid-walk is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10
   } acc_e;

   localparam logic [1:0] PRIV_SUPV = 2'b01;

   // entry bit positions
   localparam int PTE_V       = 0;
   localparam int PTE_R       = 1;
   localparam int PTE_W       = 2;
   localparam int PTE_X       = 3;
   localparam int PTE_A       = 6;
   localparam int PTE_D       = 7;
   localparam int PTE_PPN_LSB = 10;
   localparam int PTE_BITS    = 64;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_CHK,
      ST_RD_WAIT,
      ST_EVAL,
      ST_WB_CHK,
      ST_FILL,
      ST_FAULT
   } walk_st_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PAGE_BITS  = 12,
   parameter int IDX_BITS   = 9,
   parameter int PPN_W      = 44,
   parameter int VA_W       = 39,
   parameter int PA_W       = 56,
   parameter int LVL_W      = 2,
   parameter int ENTRY_LOG2 = 3
) (
   input  logic [PPN_W-1:0] base_ppn,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  pte_addr
);
   logic [IDX_BITS-1:0] idx;

   always_comb begin
      idx      = IDX_BITS'(vaddr >> (PAGE_BITS + IDX_BITS * int'(lvl)));
      pte_addr = {base_ppn, {PAGE_BITS{1'b0}}} + (PA_W'(idx) << ENTRY_LOG2);
   end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval #(
   parameter int IDX_BITS = 9,
   parameter int LEVELS   = 3,
   parameter int LVL_W    = 2
) (
   input  logic [63:0]      pte,
   input  logic [LVL_W-1:0] lvl,
   input  logic [1:0]       acc,
   output logic             invalid,
   output logic             leaf,
   output logic             perm_fault,
   output logic             misaligned,
   output logic             need_wb,
   output logic [63:0]      pte_upd,
   output logic [63:0]      pte_fill
);
   import ptw_pkg::*;

   logic [LEVELS-1:0] low_nz;

   for (genvar g = 0; g < LEVELS; g++) begin : g_field
      if (g < LEVELS - 1) begin : g_chk
         assign low_nz[g] = (int'(lvl) > g) &&
                            (pte[PTE_PPN_LSB + g*IDX_BITS +: IDX_BITS] != '0);
      end else begin : g_top
         assign low_nz[g] = 1'b0;
      end
   end

   assign misaligned = |low_nz;

   always_comb begin
      invalid = !pte[PTE_V] || (!pte[PTE_R] && pte[PTE_W]);
      leaf    = pte[PTE_R] || pte[PTE_X];
      case (acc)
         ACC_READ:  perm_fault = !pte[PTE_R];
         ACC_WRITE: perm_fault = !pte[PTE_W];
         ACC_EXEC:  perm_fault = !pte[PTE_X];
         default:   perm_fault = 1'b1;
      endcase
      pte_upd        = pte;
      pte_upd[PTE_A] = 1'b1;
      if (acc == ACC_WRITE) pte_upd[PTE_D] = 1'b1;
      need_wb  = (pte_upd != pte);
      pte_fill = pte_upd;
      if (!pte_upd[PTE_D] && acc != ACC_WRITE) pte_fill[PTE_W] = 1'b0;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int PAGE_BITS  = 12,
   parameter int IDX_BITS   = 9,
   parameter int LEVELS     = 3,
   parameter int PPN_W      = 44,
   parameter int ENTRY_LOG2 = 3,
   localparam int VA_W      = PAGE_BITS + IDX_BITS * LEVELS,
   localparam int PA_W      = PPN_W + PAGE_BITS,
   localparam int PB_W      = $clog2(VA_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   input  logic [1:0]       req_priv,
   input  logic [PPN_W-1:0] req_root,
   output logic             chk_valid,
   output logic [PA_W-1:0]  chk_addr,
   output logic [1:0]       chk_priv,
   output logic [1:0]       chk_acc,
   input  logic             chk_allow,
   output logic             mem_req_valid,
   output logic             mem_req_write,
   output logic [PA_W-1:0]  mem_req_addr,
   output logic [63:0]      mem_req_wdata,
   input  logic             mem_rsp_valid,
   input  logic [63:0]      mem_rsp_rdata,
   output logic             fill_valid,
   output logic [VA_W-1:0]  fill_vaddr,
   output logic [PPN_W-1:0] fill_ppn,
   output logic [PB_W-1:0]  fill_page_bits,
   output logic [63:0]      fill_pte,
   output logic             fault_valid,
   output logic             fault_access,
   output logic [VA_W-1:0]  fault_vaddr
);
   import ptw_pkg::*;

   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

   if (LEVELS < 1) begin : g_bad_levels
      $error("ptw_walker: LEVELS must be at least 1");
   end
   if (PTE_PPN_LSB + PPN_W > PTE_BITS) begin : g_bad_ppn
      $error("ptw_walker: page number does not fit in an entry");
   end
   if (VA_W > 64) begin : g_bad_va
      $error("ptw_walker: virtual address wider than 64 bits");
   end

   walk_st_e          state;
   logic [LVL_W-1:0]  lvl_q;
   logic [VA_W-1:0]   vaddr_q;
   logic [1:0]        acc_q;
   logic [1:0]        priv_q;
   logic [PA_W-1:0]   pte_addr_q;
   logic [63:0]       pte_q;
   logic [63:0]       wb_q;
   logic              fault_acc_q;

   // shared next-address generator
   logic [PPN_W-1:0]  ag_ppn;
   logic [VA_W-1:0]   ag_va;
   logic [LVL_W-1:0]  ag_lvl;
   logic [PA_W-1:0]   ag_addr;

   always_comb begin
      if (state == ST_IDLE) begin
         ag_ppn = req_root;
         ag_va  = req_vaddr;
         ag_lvl = TOP_LVL;
      end else begin
         ag_ppn = pte_q[PTE_PPN_LSB +: PPN_W];
         ag_va  = vaddr_q;
         ag_lvl = lvl_q - LVL_W'(1);
      end
   end

   ptw_addr_gen #(
      .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .PPN_W(PPN_W),
      .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W), .ENTRY_LOG2(ENTRY_LOG2)
   ) u_addr (
      .base_ppn(ag_ppn), .vaddr(ag_va), .lvl(ag_lvl), .pte_addr(ag_addr)
   );

   logic ev_invalid, ev_leaf, ev_perm, ev_mis, ev_need_wb;
   logic [63:0] ev_upd, ev_fill;

   ptw_pte_eval #(
      .IDX_BITS(IDX_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W)
   ) u_eval (
      .pte(pte_q), .lvl(lvl_q), .acc(acc_q),
      .invalid(ev_invalid), .leaf(ev_leaf), .perm_fault(ev_perm),
      .misaligned(ev_mis), .need_wb(ev_need_wb),
      .pte_upd(ev_upd), .pte_fill(ev_fill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         lvl_q       <= '0;
         vaddr_q     <= '0;
         acc_q       <= '0;
         priv_q      <= '0;
         pte_addr_q  <= '0;
         pte_q       <= '0;
         wb_q        <= '0;
         fault_acc_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               vaddr_q    <= req_vaddr;
               acc_q      <= req_acc;
               priv_q     <= req_priv;
               lvl_q      <= TOP_LVL;
               pte_addr_q <= ag_addr;
               state      <= ST_RD_CHK;
            end
            ST_RD_CHK: begin
               fault_acc_q <= 1'b1;
               state       <= chk_allow ? ST_RD_WAIT : ST_FAULT;
            end
            ST_RD_WAIT: if (mem_rsp_valid) begin
               pte_q <= mem_rsp_rdata;
               state <= ST_EVAL;
            end
            ST_EVAL: begin
               fault_acc_q <= 1'b0;
               if (ev_invalid) begin
                  state <= ST_FAULT;
               end else if (ev_leaf) begin
                  if (ev_perm || ev_mis) begin
                     state <= ST_FAULT;
                  end else begin
                     pte_q <= ev_fill;
                     wb_q  <= ev_upd;
                     state <= ev_need_wb ? ST_WB_CHK : ST_FILL;
                  end
               end else if (lvl_q == '0) begin
                  state <= ST_FAULT;
               end else begin
                  lvl_q      <= lvl_q - LVL_W'(1);
                  pte_addr_q <= ag_addr;
                  state      <= ST_RD_CHK;
               end
            end
            ST_WB_CHK: begin
               fault_acc_q <= 1'b1;
               state       <= chk_allow ? ST_FILL : ST_FAULT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [PB_W-1:0] page_bits;
   assign page_bits = PB_W'(PAGE_BITS + IDX_BITS * int'(lvl_q));

   always_comb begin
      req_ready      = (state == ST_IDLE);
      chk_valid      = (state == ST_RD_CHK) || (state == ST_WB_CHK);
      chk_addr       = pte_addr_q;
      chk_priv       = (state == ST_WB_CHK) ? priv_q : PRIV_SUPV;
      chk_acc        = (state == ST_WB_CHK) ? acc_q  : ACC_READ;
      mem_req_valid  = chk_valid && chk_allow;
      mem_req_write  = (state == ST_WB_CHK);
      mem_req_addr   = pte_addr_q;
      mem_req_wdata  = wb_q;
      fill_valid     = (state == ST_FILL);
      fill_page_bits = page_bits;
      fill_vaddr     = vaddr_q & ~((VA_W'(1) << page_bits) - VA_W'(1));
      fill_ppn       = pte_q[PTE_PPN_LSB +: PPN_W];
      fill_pte       = pte_q;
      fault_valid    = (state == ST_FAULT);
      fault_access   = fault_acc_q;
      fault_vaddr    = vaddr_q;
   end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W = 39,
   parameter int PA_W = 56,
   parameter int PB_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic [1:0]      req_acc,
   input logic [1:0]      req_priv,
   input logic            chk_valid,
   input logic [PA_W-1:0] chk_addr,
   input logic [1:0]      chk_priv,
   input logic [1:0]      chk_acc,
   input logic            chk_allow,
   input logic            mem_req_valid,
   input logic            mem_req_write,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            fill_valid,
   input logic [VA_W-1:0] fill_vaddr,
   input logic [PB_W-1:0] fill_page_bits,
   input logic [63:0]     fill_pte,
   input logic            fault_valid,
   input logic [VA_W-1:0] fault_vaddr
);
   logic [VA_W-1:0] cap_va;
   logic [1:0]      cap_acc, cap_priv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_va   <= '0;
         cap_acc  <= '0;
         cap_priv <= '0;
      end else if (req_valid && req_ready) begin
         cap_va   <= req_vaddr;
         cap_acc  <= req_acc;
         cap_priv <= req_priv;
      end
   end

   AST_READ_AT_SUPV: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (chk_valid && chk_allow &&
         chk_priv == 2'b01 && chk_acc == 2'b00 && chk_addr == mem_req_addr)); // R3

   AST_WB_AT_REQ_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (chk_valid && chk_allow &&
         chk_priv == cap_priv && chk_acc == cap_acc && chk_addr == mem_req_addr)); // R9

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R1

   AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault_valid)); // R12

   AST_FAULT_VADDR: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> fault_vaddr == cap_va); // R12

   AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> ((fill_vaddr & ((VA_W'(1) << fill_page_bits) - VA_W'(1))) == '0)); // R10

   AST_FILL_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> fill_pte[6]); // R8

   AST_FILL_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && cap_acc == 2'b01) |-> fill_pte[7]); // R8

   AST_CLEAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !fill_pte[7] && cap_acc != 2'b01) |-> !fill_pte[2]); // R11

   AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid || fault_valid) |=> (req_ready && !fill_valid && !fault_valid)); // R12
endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PB_W(PB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
   .req_acc(req_acc), .req_priv(req_priv),
   .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_priv(chk_priv),
   .chk_acc(chk_acc), .chk_allow(chk_allow),
   .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr),
   .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
   .fill_page_bits(fill_page_bits), .fill_pte(fill_pte),
   .fault_valid(fault_valid), .fault_vaddr(fault_vaddr)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
   localparam int VA_W = 39;
   localparam int PPN_W = 44;
   localparam int PA_W = 56;
   localparam int PB_W = 6;
   localparam logic [63:0] FV = 64'h1, FR = 64'h2, FW = 64'h4, FX = 64'h8,
                           FA = 64'h40, FD = 64'h80;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n, req_valid, req_ready;
   logic [VA_W-1:0]  req_vaddr;
   logic [1:0]       req_acc, req_priv;
   logic [PPN_W-1:0] req_root;
   logic             chk_valid, chk_allow;
   logic [PA_W-1:0]  chk_addr;
   logic [1:0]       chk_priv, chk_acc;
   logic             mem_req_valid, mem_req_write;
   logic [PA_W-1:0]  mem_req_addr;
   logic [63:0]      mem_req_wdata;
   logic             mem_rsp_valid;
   logic [63:0]      mem_rsp_rdata;
   logic             fill_valid, fault_valid, fault_access;
   logic [VA_W-1:0]  fill_vaddr, fault_vaddr;
   logic [PPN_W-1:0] fill_ppn;
   logic [PB_W-1:0]  fill_page_bits;
   logic [63:0]      fill_pte;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
      .req_root(req_root), .chk_valid(chk_valid), .chk_addr(chk_addr),
      .chk_priv(chk_priv), .chk_acc(chk_acc), .chk_allow(chk_allow),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn),
      .fill_page_bits(fill_page_bits), .fill_pte(fill_pte),
      .fault_valid(fault_valid), .fault_access(fault_access),
      .fault_vaddr(fault_vaddr)
   );

   logic [63:0]     mem [logic [PA_W-1:0]];
   logic [PA_W-1:0] deny_rd, deny_wb;
   int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, cycles = 0;
   logic [PA_W-1:0] last_wr_addr;
   logic [63:0]     last_wr_data;
   logic            rd_pend;
   logic [63:0]     rd_data;

   // protection checker model: read queries at supervisor use deny_rd, others deny_wb
   always_comb begin
      if (chk_priv == 2'b01 && chk_acc == 2'b00)
         chk_allow = (chk_addr != deny_rd);
      else
         chk_allow = (chk_addr != deny_wb);
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rd_mem(input logic [PA_W-1:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   // memory responder: read data returned one cycle after the request is seen
   always @(negedge clk) begin
      cycles++;
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_rdata = rd_data;
         rd_pend = 1'b0;
      end
      if (rst_n && mem_req_valid && !mem_req_write) begin
         check("R3 read query at supervisor/read", {59'h0, chk_valid, chk_priv, chk_acc},
               {59'h0, 1'b1, 2'b01, 2'b00});
         rd_cnt++;
         rd_pend = 1'b1;
         rd_data = rd_mem(mem_req_addr);
      end
      if (rst_n && mem_req_valid && mem_req_write) begin
         wr_cnt++;
         last_wr_addr = mem_req_addr;
         last_wr_data = mem_req_wdata;
         mem[mem_req_addr] = mem_req_wdata;
      end
   end

   // watchdog
   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   function automatic logic [63:0] mk(input logic [PPN_W-1:0] ppn, input logic [63:0] fl);
      return ({20'h0, ppn} << 10) | fl;
   endfunction

   function automatic logic [PA_W-1:0] nxt(input logic [PPN_W-1:0] ppn,
                                           input logic [VA_W-1:0] va, input int l);
      logic [63:0] ix;
      ix = (64'(va) >> (12 + 9 * l)) & 64'h1ff;
      return {ppn, 12'h0} + PA_W'(ix * 8);
   endfunction

   // behavioural reference walk; kind 0 fill, 1 page fault, 2 access fault
   task automatic model(input logic [VA_W-1:0] va, input logic [1:0] acc,
                        input logic [1:0] priv, input logic [PPN_W-1:0] root,
                        output int kind, output int lvl, output logic [63:0] fpte,
                        output bit wb, output logic [PA_W-1:0] wa,
                        output logic [63:0] wd, output int reads);
      logic [PA_W-1:0] a;
      logic [63:0] p, u;
      bit done, bad;
      kind = 1; lvl = 2; fpte = 0; wb = 0; wa = 0; wd = 0; reads = 0; done = 0;
      a = nxt(root, va, 2);
      while (!done) begin
         done = 1;
         if (a == deny_rd) begin kind = 2; end
         else begin
            p = rd_mem(a);
            reads++;
            if (!p[0] || (!p[1] && p[2])) kind = 1;
            else if (p[1] || p[3]) begin
               bad = (acc == 2'b00) ? !p[1] : (acc == 2'b01) ? !p[2] : (acc == 2'b10) ? !p[3] : 1'b1;
               for (int i = 0; i < lvl; i++)
                  if (((p >> (10 + 9 * i)) & 64'h1ff) != 0) bad = 1;
               if (bad) kind = 1;
               else begin
                  u = p | FA | ((acc == 2'b01) ? FD : 64'h0);
                  if (u != p && (priv != 2'b01 || acc != 2'b00) && a == deny_wb) kind = 2;
                  else begin
                     kind = 0;
                     wb = (u != p); wa = a; wd = u;
                     fpte = u;
                     if (!u[7] && acc != 2'b01) fpte[2] = 1'b0;
                  end
               end
            end else if (lvl == 0) kind = 1;
            else begin
               lvl--;
               a = nxt(p[53:10], va, lvl);
               done = 0;
            end
         end
      end
   endtask

   task automatic walk(input string tag, input logic [VA_W-1:0] va, input logic [1:0] acc,
                       input logic [1:0] priv, input logic [PPN_W-1:0] root, input bit poke);
      int kind, lvl, reads, w0, r0;
      logic [63:0] fpte, wd;
      logic [PA_W-1:0] wa;
      logic [VA_W-1:0] mask;
      bit wb, seen;
      model(va, acc, priv, root, kind, lvl, fpte, wb, wa, wd, reads);
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      check({tag, " R1 ready when idle"}, 64'(req_ready), 64'h1);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_priv = priv; req_root = root;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R1 busy after accept"}, 64'(req_ready), 64'h0);
      if (poke) begin
         @(negedge clk);
         req_valid = 1'b1; req_vaddr = ~va; req_acc = 2'b10; req_root = root + 1;
         @(negedge clk);
         check({tag, " R1 busy request ignored"}, 64'(req_ready), 64'h0);
         req_valid = 1'b0;
      end
      seen = 0;
      for (int t = 0; t < 200; t++) begin
         if (fill_valid || fault_valid) begin seen = 1; break; end
         @(negedge clk);
      end
      check({tag, " R12 walk ends"}, 64'(seen), 64'h1);
      if (kind == 0) begin
         mask = (VA_W'(1) << (12 + 9 * lvl)) - VA_W'(1);
         check({tag, " R12 fill pulse"}, {62'h0, fill_valid, fault_valid}, 64'h2);
         check({tag, " R10 page bits"}, 64'(fill_page_bits), 64'(12 + 9 * lvl));
         check({tag, " R10 fill vaddr"}, 64'(fill_vaddr), 64'(va & ~mask));
         check({tag, " R10 fill ppn"}, 64'(fill_ppn), 64'(fpte[53:10]));
         check({tag, " R11 fill entry"}, fill_pte, fpte);
      end else begin
         check({tag, " R12 fault pulse"}, {62'h0, fill_valid, fault_valid}, 64'h1);
         check({tag, " R12 fault kind"}, 64'(fault_access), 64'(kind == 2));
         check({tag, " R12 fault vaddr"}, 64'(fault_vaddr), 64'(va));
      end
      @(negedge clk);
      check({tag, " R12 single pulse"}, {61'h0, fill_valid, fault_valid, req_ready}, 64'h1);
      check({tag, " R2 entry reads"}, 64'(rd_cnt - r0), 64'(reads));
      check({tag, " R8 write-backs"}, 64'(wr_cnt - w0), 64'(wb));
      if (wb) begin
         check({tag, " R8 write-back addr"}, 64'(last_wr_addr), 64'(wa));
         check({tag, " R8 write-back data"}, last_wr_data, wd);
      end
   endtask

   localparam logic [VA_W-1:0] VA1 = (39'd1 << 30) | (39'd2 << 21) | (39'd3 << 12) | 39'h123;
   localparam logic [VA_W-1:0] VA2 = (39'h1ff << 21) | (39'h100 << 12) | 39'hfff;
   localparam logic [PPN_W-1:0] ROOT = 44'h100;

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_priv = '0;
      req_root = '0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0; rd_pend = 1'b0;
      rd_data = '0; deny_rd = '1; deny_wb = '1; last_wr_addr = '0; last_wr_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset ready", 64'(req_ready), 64'h1);
      check("R12 reset no result", {62'h0, fill_valid, fault_valid}, 64'h0);
      check("R3 reset no memory access", 64'(mem_req_valid), 64'h0);

      mem[56'h100008] = mk(44'h200, FV);
      mem[56'h200010] = mk(44'h300, FV);
      mem[56'h100000] = mk(44'h500, FV);
      mem[56'h500ff8] = mk(44'h600, FV);
      mem[56'h600800] = mk(44'h777, FV | FR | FA);

      mem[56'h300018] = mk(44'h4567, FV | FR | FW | FA | FD);
      walk("R2 4K read", VA1, 2'b00, 2'b01, ROOT, 1'b0);
      walk("R2 other indices", VA2, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = mk(44'h4567, FV | FR | FW);
      walk("R11 clean read", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = mk(44'h4567, FV | FR | FW);
      walk("R8 write sets A D", VA1, 2'b01, 2'b01, ROOT, 1'b1);
      mem[56'h300018] = mk(44'h4567, FV | FX | FA);
      walk("R6 exec ok", VA1, 2'b10, 2'b00, ROOT, 1'b0);
      walk("R6 read no R", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = mk(44'h4567, FV | FR | FA);
      walk("R6 write no W", VA1, 2'b01, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = 64'h0;
      walk("R4 invalid", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = mk(44'h4567, FV | FW);
      walk("R4 write-only", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h300018] = mk(44'h4567, FV);
      walk("R5 pointer at level 0", VA1, 2'b00, 2'b00, ROOT, 1'b0);

      mem[56'h200010] = mk(44'h400, FV | FR | FA);
      walk("R10 megapage", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h200010] = mk(44'h401, FV | FR | FA);
      walk("R7 misaligned megapage", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h200010] = mk(44'h300, FV);
      mem[56'h100008] = mk(44'h40000, FV | FR | FA);
      walk("R10 gigapage", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h100008] = mk(44'h40200, FV | FR | FA);
      walk("R7 gigapage middle field", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      mem[56'h100008] = mk(44'h200, FV);

      mem[56'h300018] = mk(44'h4567, FV | FR | FW | FA | FD);
      deny_rd = 56'h200010;
      walk("R3 denied entry read", VA1, 2'b00, 2'b00, ROOT, 1'b0);
      deny_rd = '1;
      mem[56'h300018] = mk(44'h4567, FV | FR | FW);
      deny_wb = 56'h300018;
      walk("R9 denied write-back", VA1, 2'b01, 2'b00, ROOT, 1'b0);
      check("R9 entry unchanged", rd_mem(56'h300018), mk(44'h4567, FV | FR | FW));
      deny_wb = '1;

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule